// File: doc/BRIEF.md
# Left-Aligned PWM Channel with Polarity

This block is one pulse-width channel that produces a left-aligned waveform. An 8-bit up-counter starts at 0 and advances once for each pulse of a clock enable. That enable is chosen from four tick sources: two base rates and two scaled rates, all generated outside the block. The counter wraps after the number of ticks held in the period register. Within each period the pin starts at a level set by the polarity bit. It changes level when the count reaches the duty value.

The polarity bit sets what the duty register means. With polarity 1, the duty value gives the high time in ticks. With polarity 0, it gives the low time, so the high time is the period minus the duty. Period, duty and polarity are copied into working registers only when a period wraps or when the channel is enabled, so every period the pin produces is whole. The alignment mode bit is captured at enable. Only left alignment produces a waveform here. When the channel is disabled, the counter is held at 0 and the pin rests at the start level that the polarity bit selects.

Top module: `pwm_left_channel`

## Requirements
- R1: While reset is asserted, pwm_o is 0 whatever the other inputs are.
- R2: While chan_en_i is 0, the counter is held at 0 and pwm_o takes, one clock later, the level of polarity_i (1 gives high, 0 gives low).
- R3: While running, the waveform repeats every P channel ticks, where P is the captured period value, and a period value of 0 means 256 ticks.
- R4: With captured polarity 1 and duty D, pwm_o is high while the count is below D and low for the rest of the period. pwm_o lags the count by one clock.
- R5: With captured polarity 0 and duty D, pwm_o is low while the count is below D and high for the rest of the period, so the high time is P minus D. For example, period 4 and duty 1 give 3 high ticks out of 4.
- R6: A duty of 0 holds pwm_o at the level opposite the start level for the whole period. A duty greater than or equal to a nonzero period holds the start level for the whole period.
- R7: clk_sel_i chooses which bit of tick_src_i advances the counter: 0 picks bit 0, 1 bit 1, 2 bit 2 and 3 bit 3. The count does not change on a clock where the chosen bit is 0.
- R8: Values on period_i, duty_i and polarity_i take effect only at the clock where the channel becomes enabled, or at the tick on which the counter wraps from P-1 to 0.
- R9: align_mode_i is captured only when the channel becomes enabled. A captured 1 (center alignment, not produced by this block) keeps pwm_o at the polarity_i level, one clock later. Changing align_mode_i while the channel runs has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_en_i | input | 1 | Channel enable |
| clk_sel_i | input | 2 | Selects the tick source bit |
| tick_src_i | input | 4 | Four clock-enable sources (base A, base B, scaled A, scaled B) |
| polarity_i | input | 1 | Start level of each period |
| align_mode_i | input | 1 | 0 left aligned, 1 center aligned (captured at enable) |
| period_i | input | 8 | Period in ticks, 0 means 256 |
| duty_i | input | 8 | Duty compare value in ticks |
| pwm_o | output | 1 | PWM pin |

## Verification
A wrong count or a missed wrap shows on pwm_o within one period. The change of level moves to the wrong tick, or the period length drifts against a model that counts ticks independently. A shadow register that loads at the wrong time shows as a period with the wrong high time, visible one clock after the bad load. A bad tick selection or a wrongly captured mode changes the pin within a few clocks of the stimulus. Comparing the pin on every clock against the expected level catches each of these at its first visible clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic {
    ALIGN_LEFT   = 1'b0,
    ALIGN_CENTER = 1'b1
  } align_e;

  typedef struct packed {
    logic   pol;
    align_e mode;
  } chan_cfg_t;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel #(
  parameter int NUM_SRC = 4,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               tick_o
);

  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i] = src_en_i[i] & (sel_i == SEL_W'(i));
  end

  assign tick_o = |hit;

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] per_s_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_q_o,
  output logic             start_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q, en_d;
  logic [CNT_W-1:0] last;

  // a zero period wraps to all ones, giving 2**CNT_W counts
  assign last = per_s_i - CNT_W'(1);

  always_comb begin
    en_d    = chan_en_i;
    cnt_d   = cnt_q;
    start_o = 1'b0;
    wrap_o  = 1'b0;
    if (!chan_en_i) begin
      cnt_d = '0;
    end else if (!en_q) begin
      cnt_d   = '0;
      start_o = 1'b1;
    end else if (tick_i) begin
      if (cnt_q == last) begin
        cnt_d  = '0;
        wrap_o = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign en_q_o = en_q;

  // R3
  cnt_le_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> (cnt_q <= last));

  // R2
  idle_cnt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |=> (cnt_q == '0) && !en_q);

  // R7
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && chan_en_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int CNT_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                wrap_i,
  input  logic [CNT_W-1:0]    per_i,
  input  logic [CNT_W-1:0]    dty_i,
  input  pwm_pkg::chan_cfg_t  cfg_i,
  output logic [CNT_W-1:0]    per_o,
  output logic [CNT_W-1:0]    dty_o,
  output pwm_pkg::chan_cfg_t  cfg_o
);

  logic [CNT_W-1:0]   per_q, per_d;
  logic [CNT_W-1:0]   dty_q, dty_d;
  pwm_pkg::chan_cfg_t cfg_q, cfg_d;
  logic               load;

  assign load = start_i | wrap_i;

  always_comb begin
    per_d = per_q;
    dty_d = dty_q;
    cfg_d = cfg_q;
    if (load) begin
      per_d     = per_i;
      dty_d     = dty_i;
      cfg_d.pol = cfg_i.pol;
    end
    if (start_i) begin
      cfg_d.mode = cfg_i.mode;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      dty_q <= '0;
      cfg_q <= '{pol: 1'b0, mode: pwm_pkg::ALIGN_LEFT};
    end else begin
      per_q <= per_d;
      dty_q <= dty_d;
      cfg_q <= cfg_d;
    end
  end

  assign per_o = per_q;
  assign dty_o = dty_q;
  assign cfg_o = cfg_q;

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] dty_i,
  input  logic             pol_i,
  input  logic             idle_lvl_i,
  output logic             pwm_o
);

  logic out_q, out_d;
  logic in_first;

  assign in_first = (cnt_i < dty_i);

  always_comb begin
    if (run_i) out_d = in_first ? pol_i : ~pol_i;
    else       out_d = idle_lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign pwm_o = out_q;

  // R6
  zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && dty_i == '0) |=> (pwm_o == !$past(pol_i)));

  // R4
  start_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && pol_i && cnt_i == '0 && dty_i != '0) |=> pwm_o);

endmodule

// File: rtl/pwm_left_channel.sv
module pwm_left_channel #(
  parameter int CNT_W   = 8,
  parameter int NUM_SRC = 4,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               chan_en_i,
  input  logic [SEL_W-1:0]   clk_sel_i,
  input  logic [NUM_SRC-1:0] tick_src_i,
  input  logic               polarity_i,
  input  logic               align_mode_i,
  input  logic [CNT_W-1:0]   period_i,
  input  logic [CNT_W-1:0]   duty_i,
  output logic               pwm_o
);

  import pwm_pkg::*;

  logic             rst_n;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             en_q;
  logic             start;
  logic             wrap;
  logic [CNT_W-1:0] per_s;
  logic [CNT_W-1:0] dty_s;
  chan_cfg_t        cfg_in;
  chan_cfg_t        cfg_s;
  logic             run;

  assign cfg_in.pol  = polarity_i;
  assign cfg_in.mode = align_e'(align_mode_i);

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  pwm_tick_sel #(.NUM_SRC(NUM_SRC)) u_sel (
    .src_en_i (tick_src_i),
    .sel_i    (clk_sel_i),
    .tick_o   (tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .chan_en_i (chan_en_i),
    .tick_i    (tick),
    .per_s_i   (per_s),
    .cnt_o     (cnt),
    .en_q_o    (en_q),
    .start_o   (start),
    .wrap_o    (wrap)
  );

  pwm_shadow #(.CNT_W(CNT_W)) u_shd (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (start),
    .wrap_i  (wrap),
    .per_i   (period_i),
    .dty_i   (duty_i),
    .cfg_i   (cfg_in),
    .per_o   (per_s),
    .dty_o   (dty_s),
    .cfg_o   (cfg_s)
  );

  assign run = en_q & (cfg_s.mode == ALIGN_LEFT);

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .run_i      (run),
    .cnt_i      (cnt),
    .dty_i      (dty_s),
    .pol_i      (cfg_s.pol),
    .idle_lvl_i (polarity_i),
    .pwm_o      (pwm_o)
  );

  // R8
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_q && cnt != '0) |-> ($stable(dty_s) && $stable(per_s)));

  // R9
  center_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_q && cfg_s.mode == ALIGN_CENTER) |=> (pwm_o == $past(polarity_i)));

  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_n |=> (!rst_n ? 1'b1 : 1'b1) && (pwm_o == 1'b0 || rst_n));

endmodule

// File: tb/tb_pwm_left_channel.sv
module tb_pwm_left_channel;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [1:0] sel;
  logic [3:0] src;
  logic       pol;
  logic       mode;
  logic [7:0] per;
  logic [7:0] dty;
  logic       pwm;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  bit    exp_q[$];
  string tag_q[$];

  // reference model state
  bit m_en;
  int m_cnt;
  int m_per;
  int m_dty;
  bit m_pol;
  bit m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int div_of(int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 5;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++) src[i] = ((cyc % div_of(i)) == 0);
  end

  pwm_left_channel dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .chan_en_i    (en),
    .clk_sel_i    (sel),
    .tick_src_i   (src),
    .polarity_i   (pol),
    .align_mode_i (mode),
    .period_i     (per),
    .duty_i       (dty),
    .pwm_o        (pwm)
  );

  // driver: models one clock edge and pushes the level expected after it
  task automatic step(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      bit e;
      bit tk;
      int plen;
      @(posedge clk);
      #2;
      tk = (((cyc - 1) % div_of(int'(sel))) == 0);
      if (m_en && !m_mode) e = (m_cnt < m_dty) ? m_pol : !m_pol;
      else                 e = pol;
      plen = (m_per == 0) ? 256 : m_per;
      if (!en) begin
        m_en = 0; m_cnt = 0;
      end else if (!m_en) begin
        m_en = 1; m_cnt = 0;
        m_per = int'(per); m_dty = int'(dty); m_pol = pol; m_mode = mode;
      end else if (tk) begin
        if (m_cnt == plen - 1) begin
          m_cnt = 0;
          m_per = int'(per); m_dty = int'(dty); m_pol = pol;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pwm !== e) begin
        errors++;
        $display("FAIL %s: pwm_o=%b expected %b at cycle %0d", t, pwm, e, cyc);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 0; sel = 0; pol = 1; mode = 0; per = 4; dty = 1;
    m_en = 0; m_cnt = 0; m_per = 0; m_dty = 0; m_pol = 0; m_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pwm !== 1'b0) begin
      errors++;
      $display("FAIL R1: pwm_o=%b expected 0 in reset", pwm);
    end
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;

    // R2: idle level follows polarity
    pol = 0; step(4, "R2");
    pol = 1; step(4, "R2");
    pol = 0; step(2, "R2");

    // R5: period 4, duty 1, polarity 0 -> 3 of 4 high
    per = 4; dty = 1; pol = 0; sel = 0; en = 1;
    step(17, "R5");

    // R4: polarity 1
    en = 0; step(2, "R4");
    per = 5; dty = 2; pol = 1; en = 1;
    step(21, "R4");

    // R3: period 0 means 256
    en = 0; step(2, "R3");
    per = 0; dty = 100; pol = 1; en = 1;
    step(560, "R3");
    per = 7; dty = 3;
    step(300, "R3");

    // R6: duty 0 and duty at or above period
    en = 0; step(2, "R6");
    per = 6; dty = 0; pol = 1; en = 1;
    step(15, "R6");
    dty = 9; step(15, "R6");
    dty = 6; pol = 0; step(15, "R6");

    // R7: tick source selection
    en = 0; step(2, "R7");
    per = 3; dty = 1; pol = 1; en = 1;
    sel = 1; step(40, "R7");
    sel = 2; step(40, "R7");
    sel = 3; step(40, "R7");
    sel = 0; step(10, "R7");

    // R8: shadowed updates
    en = 0; step(2, "R8");
    per = 8; dty = 2; pol = 1; en = 1;
    step(3, "R8");
    dty = 5; per = 4; pol = 0;
    step(30, "R8");

    // R9: mode captured at enable only
    en = 0; step(2, "R9");
    mode = 1; pol = 1; per = 4; dty = 2; en = 1;
    step(10, "R9");
    pol = 0; step(4, "R9");
    mode = 0; step(10, "R9");
    en = 0; step(2, "R9");
    mode = 0; pol = 1; en = 1;
    step(5, "R9");
    mode = 1; step(20, "R9");

    en = 0; step(3, "R2");

    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule